// File: doc/BRIEF.md
# Conditional Skip Evaluator

This block decides the sixteen conditional-skip operations of a processor whose instructions are all one 16-bit word. When an evaluation is requested, it takes a 4-bit condition code, the two operand registers (called Rx and Ry here), and the program counter. That counter is byte-addressed and already points at the instruction that follows the skip. The block tests the condition on byte-wide fields of the operands. If the condition holds, it moves the counter past the following instruction. If it does not hold, it returns the counter unchanged.

The conditions come in eight pairs. The upper bit of the code inverts the test selected by the lower three bits. The tests cover unsigned comparisons of the two low bytes, zero and all-ones tests of Rx's low byte, and mask tests that take Ry's low byte as the mask. The mask tests are applied to either the low byte or the high byte of Rx. Each result is registered and comes out one clock after the request, together with a one-cycle completion strobe.

Top module: `skip_eval`

## Requirements
- R1: While rst_n is low, and on the first edge after it is released with no request, pc_o, skip_o and done_o are all 0.
- R2: done_o is 1 in the cycle after a cycle with eval_i high, and 0 in the cycle after a cycle with eval_i low.
- R3: Codes 0, 1 and 2 skip when Rx[7:0] is unsigned less-or-equal, less than, or equal to Ry[7:0] respectively.
- R4: Codes 8, 9 and 10 skip exactly when codes 0, 1 and 2 would not, that is on greater, greater-or-equal and not-equal.
- R5: Code 3 skips when Rx[7:0] is 0x00, and code 11 skips when it is not. Rx[15:8] has no effect on either.
- R6: Code 4 skips when Rx[7:0] is 0xFF, and code 12 skips when it is not.
- R7: Code 5 skips when every bit set in Ry[7:0] is also set in Rx[7:0]. Code 13 is its negation. Ry[15:8] has no effect.
- R8: Code 6 skips when every bit set in Ry[7:0] is clear in Rx[7:0]. Code 14 is its negation.
- R9: Code 7 skips when every bit set in Ry[7:0] is also set in Rx[15:8]. Code 15 is its negation.
- R10: After a request, pc_o equals the requested pc_i plus 2 when the skip is taken, and pc_i unchanged when it is not, wrapping modulo 2^PC_W. skip_o shows whether the skip was taken.
- R11: In a cycle with eval_i low, pc_o and skip_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_i | input | 1 | Request an evaluation this cycle |
| cond_i | input | 4 | Condition code |
| rx_i | input | 16 | Rx operand |
| ry_i | input | 16 | Ry operand (low byte used) |
| pc_i | input | PC_W | Program counter of the next instruction |
| pc_o | output | PC_W | Updated program counter |
| skip_o | output | 1 | Skip was taken |
| done_o | output | 1 | Result valid strobe |

## Verification
Every result appears exactly one clock edge after the cycle in which eval_i was sampled high. The bench drives each request on a falling edge and holds it across one rising edge. It then compares pc_o, skip_o and done_o on the next falling edge, before anything else can change them. To show that the outputs hold and that the strobe clears, the bench waits one more edge with eval_i low and samples again. There it expects done_o to be 0 and the earlier pc_o and skip_o to be unchanged.

// File: rtl/skip_eval.sv
module skip_eval #(
  parameter int PC_W = 16,
  parameter int STEP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            eval_i,
  input  logic [3:0]      cond_i,
  input  logic [15:0]     rx_i,
  input  logic [15:0]     ry_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] pc_o,
  output logic            skip_o,
  output logic            done_o
);
  localparam logic [PC_W-1:0] INC = PC_W'(STEP);

  logic [7:0] xl, xh, yl;
  logic       base, hit;

  assign xl = rx_i[7:0];
  assign xh = rx_i[15:8];
  assign yl = ry_i[7:0];

  always_comb begin
    unique case (cond_i[2:0])
      3'd0: base = (xl <= yl);
      3'd1: base = (xl <  yl);
      3'd2: base = (xl == yl);
      3'd3: base = (xl == 8'h00);
      3'd4: base = (xl == 8'hFF);
      3'd5: base = ((xl & yl) == yl);
      3'd6: base = ((xl & yl) == 8'h00);
      default: base = ((xh & yl) == yl);
    endcase
  end

  assign hit = base ^ cond_i[3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o   <= '0;
      skip_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= eval_i;
      if (eval_i) begin
        skip_o <= hit;
        pc_o   <= hit ? pc_i + INC : pc_i;
      end
    end
  end
endmodule

module skip_eval_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            eval_i,
  input logic [3:0]      cond_i,
  input logic [15:0]     rx_i,
  input logic [15:0]     ry_i,
  input logic [PC_W-1:0] pc_i,
  input logic [PC_W-1:0] pc_o,
  input logic            skip_o,
  input logic            done_o
);
  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i |=> done_o);
  // R2
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> !done_o);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_i |=> ($stable(pc_o) && $stable(skip_o)));
  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i |=> (pc_o == (skip_o ? $past(pc_i) + PC_W'(2) : $past(pc_i))));
  // R3
  eq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && cond_i == 4'd2) |=> (skip_o == ($past(rx_i[7:0]) == $past(ry_i[7:0]))));
  // R5
  nz_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && cond_i == 4'd11) |=> (skip_o == ($past(rx_i[7:0]) != 8'h00)));
endmodule

bind skip_eval skip_eval_chk #(.PC_W(PC_W)) i_skip_eval_chk (.*);

// File: tb/test_skip_eval.sv
module test_skip_eval;
  localparam int PC_W = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            eval_i = 1'b0;
  logic [3:0]      cond_i = '0;
  logic [15:0]     rx_i = '0;
  logic [15:0]     ry_i = '0;
  logic [PC_W-1:0] pc_i = '0;
  logic [PC_W-1:0] pc_o;
  logic            skip_o;
  logic            done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  skip_eval #(.PC_W(PC_W)) i_skip_eval (.*);

  always #4 clk = ~clk;

  function automatic bit model(input logic [3:0] c, input logic [15:0] x, input logic [15:0] y);
    bit b;
    case (c[2:0])
      3'd0: b = x[7:0] <= y[7:0];
      3'd1: b = x[7:0] <  y[7:0];
      3'd2: b = x[7:0] == y[7:0];
      3'd3: b = x[7:0] == 8'h00;
      3'd4: b = x[7:0] == 8'hFF;
      3'd5: b = (y[7:0] & ~x[7:0]) == 8'h00;
      3'd6: b = (y[7:0] & x[7:0]) == 8'h00;
      default: b = (y[7:0] & ~x[15:8]) == 8'h00;
    endcase
    return c[3] ? !b : b;
  endfunction

  function automatic string req_of(input logic [3:0] c);
    case (c)
      4'd0, 4'd1, 4'd2: return "R3";
      4'd8, 4'd9, 4'd10: return "R4";
      4'd3, 4'd11: return "R5";
      4'd4, 4'd12: return "R6";
      4'd5, 4'd13: return "R7";
      4'd6, 4'd14: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [15:0] x, input logic [15:0] y,
                       input logic [PC_W-1:0] p);
    bit s;
    logic [PC_W-1:0] ep;
    s  = model(c, x, y);
    ep = s ? p + PC_W'(2) : p;
    @(negedge clk);
    eval_i = 1'b1; cond_i = c; rx_i = x; ry_i = y; pc_i = p;
    @(negedge clk);
    eval_i = 1'b0;
    check(req_of(c), 32'(skip_o), 32'(s));
    check("R10", 32'(pc_o), 32'(ep));
    check("R2", 32'(done_o), 32'd1);
    cond_i = ~c; rx_i = ~x; ry_i = ~y; pc_i = ~p;
    @(negedge clk);
    check("R11", 32'(pc_o), 32'(ep));
    check("R11", 32'(skip_o), 32'(s));
    check("R2", 32'(done_o), 32'd0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1
    check("R1", 32'(pc_o), 32'd0);
    check("R1", 32'(skip_o), 32'd0);
    check("R1", 32'(done_o), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 32'(done_o), 32'd0);
    check("R1", 32'(pc_o), 32'd0);

    // R3 R4 boundaries: equal, one apart, with differing high bytes
    for (int c = 0; c < 16; c++) begin
      apply(4'(c), 16'hAB40, 16'h1240, 16'h0100);
      apply(4'(c), 16'h003F, 16'hFF40, 16'h0200);
      apply(4'(c), 16'h0041, 16'h0040, 16'h0300);
    end
    // R5 zero low byte with nonzero high byte; R6 all-ones
    apply(4'd3,  16'hFF00, 16'h0000, 16'h1000);
    apply(4'd11, 16'hFF00, 16'h0000, 16'h1002);
    apply(4'd4,  16'h00FF, 16'h0000, 16'h1004);
    apply(4'd12, 16'h00FE, 16'h0000, 16'h1006);
    // R7 R8 R9 masks, high byte of Ry must not matter; empty mask
    apply(4'd5,  16'h00F3, 16'hFF33, 16'h2000);
    apply(4'd13, 16'h00F3, 16'hFF37, 16'h2002);
    apply(4'd6,  16'h00C0, 16'hFF0F, 16'h2004);
    apply(4'd14, 16'h00C1, 16'h000F, 16'h2006);
    apply(4'd7,  16'h8100, 16'h0081, 16'h2008);
    apply(4'd15, 16'h0081, 16'h0081, 16'h200A);
    apply(4'd5,  16'h0000, 16'h0000, 16'h200C);
    // R10 wrap
    apply(4'd2, 16'h0007, 16'h0007, 16'hFFFE);
    apply(4'd2, 16'h0007, 16'h0007, 16'hFFFF);

    for (int n = 0; n < 3000; n++) begin
      logic [15:0] x, y;
      x = 16'($urandom);
      y = 16'($urandom);
      if (n % 5 == 0) y[7:0] = x[7:0];
      if (n % 7 == 0) x[7:0] = 8'hFF;
      if (n % 11 == 0) x[7:0] = 8'h00;
      apply(4'($urandom), x, y, 16'($urandom));
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule